// File: doc/BRIEF.md
# Address-Range Monitor Wait Unit

This block holds the monitor-and-wait state for one processor core. A privileged arm command captures an address and begins watching the aligned 64-byte line that holds it. A privileged wait command then either puts the core in an idle stall or, if the monitor has already been triggered, finishes at once as a no-op. Store addresses from other agents are snooped against the watched line. A set of wake and trigger inputs decides when a pending wait ends or when an armed monitor becomes triggered.

The core issues arm and wait as one-cycle requests along with its current privilege level. It stalls while `idle` is high and continues when it sees `resume` or `wait_nop`. `illegal_op` tells the core that a request was made at a privilege level other than 0. In that case the request is dropped.

Top module: `mwait_unit`

## Requirements
- R1: After reset the monitor is unarmed and `idle`, `resume`, `wait_nop` and `illegal_op` are all low.
- R2: After an arm, a snooped store whose address bits [ADDR_W-1:6] equal those of the armed address triggers the monitor. A later wait then gives a one-cycle `wait_nop` pulse in the cycle after the request, and `idle` stays low.
- R3: A snooped store to any other line leaves an armed monitor armed.
- R4: A wait issued while armed and untriggered raises `idle` in the cycle after the request. `idle` stays high until a wake condition is seen.
- R5: While idle, a snoop hit on the watched line produces a `resume` pulse exactly one cycle long in the cycle after the hit. `idle` falls in that same cycle.
- R6: Any single bit of `ext_wake` wakes an idle core, with the same timing as R5. The bit order is: non-maskable, system-management, init, bus-init, machine-check error, address-bit-20 mask.
- R7: `fault` wakes an idle core. While the monitor is armed or triggered, `fault` changes nothing.
- R8: `tlb_inval` or `far_xfer` seen while armed triggers the monitor, so the next wait is a no-op.
- R9: `pm_event` has no effect. It does not clear a triggered monitor and it does not wake an idle core.
- R10: An arm or wait at a privilege level other than 0 gives a one-cycle `illegal_op` pulse in the next cycle and leaves the monitor state unchanged.
- R11: After a resume the monitor is unarmed, so a wait without a new arm is a no-op.
- R12: A wait while unarmed gives a `wait_nop` pulse and never raises `idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_lvl | input | 2 | Current privilege level of the core |
| arm_req | input | 1 | Arm command, one cycle |
| arm_addr | input | ADDR_W | Address captured by arm |
| wait_req | input | 1 | Wait command, one cycle |
| snoop_valid | input | 1 | Store from another agent is present |
| snoop_addr | input | ADDR_W | Address of that store |
| ext_wake | input | N_IRQ | External interrupt wake lines |
| fault | input | 1 | Fault or abort |
| tlb_inval | input | 1 | Control-register, model-register or status-word write that invalidates translations |
| far_xfer | input | 1 | Fast system call or far call |
| pm_event | input | 1 | Thermal throttle or clock-stop request |
| idle | output | 1 | Core is stalled in wait |
| resume | output | 1 | One-cycle wake pulse |
| wait_nop | output | 1 | Wait finished at once as a no-op |
| illegal_op | output | 1 | Request made at a non-zero privilege level |

## Verification
The properties assume that the core issues no arm or wait while it is stalled. They also assume that `tlb_inval` and `far_xfer` stay low during a stall, because the core cannot run instructions then, and that arm and wait never arrive in the same cycle. The stimulus follows these rules: every command is issued only after the previous outcome has been observed, and the wake stimulus is applied only during a stall. Each stimulus cycle holds at most one event, so every expected output can be traced to a single cause.

// File: rtl/mwait_pkg.sv
package mwait_pkg;

    typedef enum logic [1:0] {
        MON_IDLE  = 2'd0,
        MON_ARMED = 2'd1,
        MON_TRIG  = 2'd2,
        MON_WAIT  = 2'd3
    } mon_state_e;

    typedef struct packed {
        logic arm_ok;
        logic wait_ok;
        logic bad_priv;
    } mon_cmd_t;

    typedef struct packed {
        logic resume;
        logic wait_nop;
        logic illegal;
    } mon_pulse_t;

    function automatic logic priv_allowed(input logic [1:0] lvl);
        return lvl == 2'd0;
    endfunction

endpackage

// File: rtl/mon_line_cmp.sv
module mon_line_cmp #(
    parameter int ADDR_W     = 32,
    parameter int LINE_SHIFT = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              hit
);
    localparam int TAG_W = ADDR_W - LINE_SHIFT;

    logic [TAG_W-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else if (load) begin
            tag_q <= load_addr[ADDR_W-1:LINE_SHIFT];
        end
    end

    assign hit = snp_valid && (snp_addr[ADDR_W-1:LINE_SHIFT] == tag_q);
endmodule

// File: rtl/mon_wake_src.sv
module mon_wake_src #(
    parameter int N_IRQ = 6
) (
    input  logic             snoop_hit,
    input  logic [N_IRQ-1:0] ext_wake,
    input  logic             fault,
    input  logic             tlb_inval,
    input  logic             far_xfer,
    output logic             trig,
    output logic             wake
);
    logic [N_IRQ:0] irq_or;

    assign irq_or[0] = 1'b0;
    for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
        assign irq_or[i+1] = irq_or[i] | ext_wake[i];
    end

    // Events that arm-to-wait ordering turns into a trigger
    assign trig = snoop_hit | tlb_inval | far_xfer;
    // Events that end a stall
    assign wake = snoop_hit | irq_or[N_IRQ] | fault;
endmodule

// File: rtl/mon_fsm.sv
module mon_fsm
    import mwait_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  mon_cmd_t   cmd,
    input  logic       trig,
    input  logic       wake,
    output mon_state_e state,
    output mon_pulse_t pulses
);
    mon_state_e state_q;
    mon_pulse_t pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MON_IDLE;
            pulse_q <= '0;
        end else begin
            pulse_q <= '0;
            if (state_q == MON_WAIT) begin
                if (wake) begin
                    state_q        <= MON_IDLE;
                    pulse_q.resume <= 1'b1;
                end
            end else if (cmd.bad_priv) begin
                pulse_q.illegal <= 1'b1;
                if (state_q == MON_ARMED && trig) begin
                    state_q <= MON_TRIG;
                end
            end else if (cmd.arm_ok) begin
                state_q <= MON_ARMED;
            end else if (cmd.wait_ok) begin
                if (state_q == MON_ARMED && !trig) begin
                    state_q <= MON_WAIT;
                end else begin
                    state_q          <= MON_IDLE;
                    pulse_q.wait_nop <= 1'b1;
                end
            end else if (state_q == MON_ARMED && trig) begin
                state_q <= MON_TRIG;
            end
        end
    end

    assign state  = state_q;
    assign pulses = pulse_q;
endmodule

// File: rtl/mwait_unit.sv
module mwait_unit
    import mwait_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_SHIFT = 6,
    parameter int N_IRQ      = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        priv_lvl,
    input  logic              arm_req,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic              wait_req,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic [N_IRQ-1:0]  ext_wake,
    input  logic              fault,
    input  logic              tlb_inval,
    input  logic              far_xfer,
    input  logic              pm_event,
    output logic              idle,
    output logic              resume,
    output logic              wait_nop,
    output logic              illegal_op
);
    mon_cmd_t   cmd;
    mon_state_e state;
    mon_pulse_t pulses;
    logic       hit;
    logic       trig;
    logic       wake;
    logic       ok;

    assign ok           = priv_allowed(priv_lvl);
    assign cmd.bad_priv = (arm_req | wait_req) & ~ok;
    assign cmd.arm_ok   = arm_req & ok;
    assign cmd.wait_ok  = wait_req & ok & ~arm_req;

    mon_line_cmp #(.ADDR_W(ADDR_W), .LINE_SHIFT(LINE_SHIFT)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .load      (cmd.arm_ok && state != MON_WAIT),
        .load_addr (arm_addr),
        .snp_valid (snoop_valid),
        .snp_addr  (snoop_addr),
        .hit       (hit)
    );

    mon_wake_src #(.N_IRQ(N_IRQ)) u_src (
        .snoop_hit (hit),
        .ext_wake  (ext_wake),
        .fault     (fault),
        .tlb_inval (tlb_inval),
        .far_xfer  (far_xfer),
        .trig      (trig),
        .wake      (wake)
    );

    mon_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .trig   (trig),
        .wake   (wake),
        .state  (state),
        .pulses (pulses)
    );

    // Power-management requests reach the unit but never alter its state
    logic pm_unused;
    assign pm_unused = pm_event;

    assign idle       = (state == MON_WAIT);
    assign resume     = pulses.resume;
    assign wait_nop   = pulses.wait_nop;
    assign illegal_op = pulses.illegal;
endmodule

// File: rtl/mwait_unit_chk.sv
module mwait_unit_chk #(
    parameter int ADDR_W = 32,
    parameter int N_IRQ  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        priv_lvl,
    input logic              wait_req,
    input logic              snoop_valid,
    input logic [N_IRQ-1:0]  ext_wake,
    input logic              fault,
    input logic              idle,
    input logic              resume,
    input logic              wait_nop,
    input logic              illegal_op
);
    assert_resume_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        resume |=> !resume);

    assert_resume_drops_idle_R5: assert property (@(posedge clk) disable iff (rst)
        resume |-> !idle && $past(idle));

    assert_idle_from_wait_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(idle) |-> $past(wait_req) && $past(priv_lvl) == 2'd0);

    // R9: with no wake source present, a stall persists whatever pm_event does
    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (idle && !snoop_valid && ext_wake == '0 && !fault) |=> idle);

    assert_nop_no_idle_R2: assert property (@(posedge clk) disable iff (rst)
        wait_nop |-> !idle);

    assert_illegal_no_idle_R10: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> !idle && !$rose(idle));

    assert_pulses_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({resume, wait_nop, illegal_op}));
endmodule

bind mwait_unit mwait_unit_chk #(.ADDR_W(ADDR_W), .N_IRQ(N_IRQ)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .priv_lvl    (priv_lvl),
    .wait_req    (wait_req),
    .snoop_valid (snoop_valid),
    .ext_wake    (ext_wake),
    .fault       (fault),
    .idle        (idle),
    .resume      (resume),
    .wait_nop    (wait_nop),
    .illegal_op  (illegal_op)
);

// File: tb/mwait_unit_tb_top.sv
module mwait_unit_tb_top;
    localparam int AW = 32;
    localparam int NI = 6;

    typedef struct {
        logic          arm;
        logic          wt;
        logic [AW-1:0] aaddr;
        logic          snp;
        logic [AW-1:0] saddr;
        logic [NI-1:0] irq;
        logic          flt;
        logic          tlb;
        logic          far;
        logic          pm;
        logic [1:0]    priv;
    } stim_t;

    typedef struct {
        logic  idle;
        logic  resume;
        logic  nop;
        logic  ill;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    priv_lvl = '0;
    logic          arm_req = 1'b0;
    logic [AW-1:0] arm_addr = '0;
    logic          wait_req = 1'b0;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic [NI-1:0] ext_wake = '0;
    logic          fault = 1'b0;
    logic          tlb_inval = 1'b0;
    logic          far_xfer = 1'b0;
    logic          pm_event = 1'b0;
    logic          idle, resume, wait_nop, illegal_op;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t sb_q[$];

    localparam logic [AW-1:0] LINE_A   = 32'h1000_0040;
    localparam logic [AW-1:0] SAME_A   = 32'h1000_007C;
    localparam logic [AW-1:0] OTHER_A  = 32'h1000_0080;

    always #10 clk = ~clk;

    mwait_unit #(.ADDR_W(AW), .LINE_SHIFT(6), .N_IRQ(NI)) dut_i (
        .clk (clk), .rst (rst), .priv_lvl (priv_lvl),
        .arm_req (arm_req), .arm_addr (arm_addr), .wait_req (wait_req),
        .snoop_valid (snoop_valid), .snoop_addr (snoop_addr),
        .ext_wake (ext_wake), .fault (fault), .tlb_inval (tlb_inval),
        .far_xfer (far_xfer), .pm_event (pm_event),
        .idle (idle), .resume (resume), .wait_nop (wait_nop),
        .illegal_op (illegal_op)
    );

    function automatic stim_t quiet();
        stim_t s;
        s.arm = 0; s.wt = 0; s.aaddr = '0; s.snp = 0; s.saddr = '0;
        s.irq = '0; s.flt = 0; s.tlb = 0; s.far = 0; s.pm = 0; s.priv = 2'd0;
        return s;
    endfunction

    // Driver: one cycle of stimulus, expectation for outputs after that edge
    task automatic step(input stim_t s, input logic e_idle, input logic e_res,
                        input logic e_nop, input logic e_ill, input string tag);
        exp_t e;
        priv_lvl = s.priv; arm_req = s.arm; arm_addr = s.aaddr; wait_req = s.wt;
        snoop_valid = s.snp; snoop_addr = s.saddr; ext_wake = s.irq;
        fault = s.flt; tlb_inval = s.tlb; far_xfer = s.far; pm_event = s.pm;
        @(posedge clk);
        e.idle = e_idle; e.resume = e_res; e.nop = e_nop; e.ill = e_ill; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        priv_lvl = '0; arm_req = 0; wait_req = 0; snoop_valid = 0;
        ext_wake = '0; fault = 0; tlb_inval = 0; far_xfer = 0; pm_event = 0;
    endtask

    // Monitor: pop and compare away from the edge
    always @(posedge clk) begin
        #5;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if ({idle, resume, wait_nop, illegal_op} !== {e.idle, e.resume, e.nop, e.ill}) begin
                errors++;
                $display("FAIL %s: idle/resume/nop/ill actual=%b%b%b%b expected=%b%b%b%b",
                         e.tag, idle, resume, wait_nop, illegal_op,
                         e.idle, e.resume, e.nop, e.ill);
            end
        end
    end

    task automatic do_arm(input string tag);
        stim_t s = quiet();
        s.arm = 1; s.aaddr = LINE_A;
        step(s, 0, 0, 0, 0, tag);
    endtask

    task automatic do_wait(input logic e_idle, input logic e_nop, input string tag);
        stim_t s = quiet();
        s.wt = 1;
        step(s, e_idle, 0, e_nop, 0, tag);
    endtask

    initial begin
        stim_t s;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1
        step(quiet(), 0, 0, 0, 0, "R1 reset state");
        // R12
        do_wait(0, 1, "R12 wait unarmed");
        // R2
        do_arm("R2 arm");
        s = quiet(); s.snp = 1; s.saddr = SAME_A;
        step(s, 0, 0, 0, 0, "R2 hit triggers");
        do_wait(0, 1, "R2 wait after trigger");
        // R3/R4/R9/R5/R11
        do_arm("R3 arm");
        s = quiet(); s.snp = 1; s.saddr = OTHER_A;
        step(s, 0, 0, 0, 0, "R3 other line");
        do_wait(1, 0, "R3 R4 wait idles");
        step(quiet(), 1, 0, 0, 0, "R4 idle held");
        s = quiet(); s.pm = 1;
        step(s, 1, 0, 0, 0, "R9 pm no wake");
        s = quiet(); s.snp = 1; s.saddr = LINE_A;
        step(s, 0, 1, 0, 0, "R5 hit wakes");
        step(quiet(), 0, 0, 0, 0, "R5 pulse ends");
        do_wait(0, 1, "R11 unarmed after resume");
        // R6
        for (int i = 0; i < NI; i++) begin
            do_arm("R6 arm");
            do_wait(1, 0, "R6 wait");
            s = quiet(); s.irq = NI'(1) << i;
            step(s, 0, 1, 0, 0, $sformatf("R6 irq bit %0d", i));
        end
        // R7
        do_arm("R7 arm");
        s = quiet(); s.flt = 1;
        step(s, 0, 0, 0, 0, "R7 fault while armed");
        do_wait(1, 0, "R7 still armed");
        s = quiet(); s.flt = 1;
        step(s, 0, 1, 0, 0, "R7 fault wakes");
        // R8
        do_arm("R8 arm");
        s = quiet(); s.tlb = 1;
        step(s, 0, 0, 0, 0, "R8 tlb");
        do_wait(0, 1, "R8 tlb triggered");
        do_arm("R8 arm");
        s = quiet(); s.far = 1;
        step(s, 0, 0, 0, 0, "R8 far");
        do_wait(0, 1, "R8 far triggered");
        // R7/R9 pending flag kept
        do_arm("R9 arm");
        s = quiet(); s.snp = 1; s.saddr = LINE_A;
        step(s, 0, 0, 0, 0, "R9 trigger");
        s = quiet(); s.flt = 1;
        step(s, 0, 0, 0, 0, "R7 fault while triggered");
        s = quiet(); s.pm = 1;
        step(s, 0, 0, 0, 0, "R9 pm while triggered");
        do_wait(0, 1, "R9 still triggered");
        // R10
        s = quiet(); s.arm = 1; s.aaddr = LINE_A; s.priv = 2'd2;
        step(s, 0, 0, 0, 1, "R10 arm bad priv");
        do_wait(0, 1, "R10 arm had no effect");
        do_arm("R10 arm");
        s = quiet(); s.wt = 1; s.priv = 2'd3;
        step(s, 0, 0, 0, 1, "R10 wait bad priv");
        do_wait(1, 0, "R10 still armed");
        s = quiet(); s.irq = 1;
        step(s, 0, 1, 0, 0, "R10 wake");
        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule